// File: doc/BRIEF.md
# Trilinear Reconstruction and Gradient Extractor

This block takes the eight corner samples of one cubic cell of a scalar volume together with a fractional position inside that cell. It returns the reconstructed scalar at that position and a three-component gradient. A ray-casting pipeline uses it to feed classification and shading, one resample point at a time.

The block has two operating modes. In fast mode a single corner set enters on each clock. The gradient comes from the intermediate face values of the interpolation tree, so it costs three subtractors. In quality mode the caller presents four sets for one resample point: the centre set, then one set of outward neighbours per axis. The block forms a central difference at every corner and runs each difference set through the same interpolation tree. This mode delivers one result per four accepted sets.

Top module: `trilin_grad_extractor`

## Requirements
- R1: While `rst` is high, and after it falls until the first result, `out_valid` and `out_err` are 0 and `out_value`, `out_gx`, `out_gy`, `out_gz` are 0.
- R2: Corner i sits at bits [16i+15:16i] of `in_samples`, with i bit 0 = x, bit 1 = y, bit 2 = z (a set bit is the far side). Every linear step computes a + floor((b-a)*f/256). Four x-edges are built with `in_fx`, and four y-edges at x=0/1 with `in_fy`. The faces are x0 = z-step(y-edges x=0), x1 = z-step(y-edges x=1), y0/y1 = z-step(x-edges at y=0/1), z0/z1 = y-step(x-edges at z=0/1), all z-steps using `in_fz`. In fast mode (`in_mode`=0) `out_value` = z-step(z0, z1).
- R3: In fast mode `out_gx` = x1 - x0, `out_gy` = y1 - y0, `out_gz` = z1 - z0, signed 17-bit.
- R4: In fast mode a set is accepted on every clock with `in_valid`=1. Its result appears with a one-cycle `out_valid` pulse after the 4th rising edge following the edge that sampled it.
- R5: In quality mode (`in_mode`=1) `in_tag` codes are 0 = centre, 1 = x-neighbours, 2 = y-neighbours, 3 = z-neighbours, and they must come in that order. Idle cycles between them are allowed. The result appears 4 edges after the tag-3 set is sampled. Its `out_value` is the R2 interpolation of the centre set.
- R6: For the axis k of a neighbour set N, and with centre set S, each corner i gets g = (S[i^2^k] - N[i]) >>> 1 if bit k of i is 0, else (N[i] - S[i^2^k]) >>> 1. This uses floor halving. The value set g is interpolated per R2 and gives `out_gx`, `out_gy` or `out_gz`.
- R7: A quality-mode set whose tag is not the expected one is dropped. It raises `out_err` for exactly one cycle after the edge that sampled it, and the block then expects a tag-0 set. A broken sequence produces no result.
- R8: A fast-mode set arriving in the middle of a quality sequence is processed normally and raises no error. It abandons that sequence, so the next quality set must carry tag 0.
- R9: Every linear step yields a value between its two operands, so a fast-mode `out_value` lies between the smallest and the largest corner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A corner set is present |
| in_mode | input | 1 | 0 = fast, 1 = quality |
| in_tag | input | 2 | Quality set kind: 0 centre, 1 x, 2 y, 3 z |
| in_samples | input | 128 | Eight unsigned 16-bit corner samples |
| in_fx | input | 8 | Fractional x offset |
| in_fy | input | 8 | Fractional y offset |
| in_fz | input | 8 | Fractional z offset |
| out_valid | output | 1 | Result pulse |
| out_value | output | 16 | Reconstructed value |
| out_gx | output | 17 | Signed x gradient |
| out_gy | output | 17 | Signed y gradient |
| out_gz | output | 17 | Signed z gradient |
| out_err | output | 1 | Out-of-order quality set seen |

## Verification
A stale stored centre set shows up in the next quality result: all three gradients are wrong, but the value is still correct. A slipped tag expectation shows up within one clock as a spurious or missing `out_err`, and a whole result then goes missing or appears extra. Miswired edge or face operands break `out_value` or one gradient for every fast set, and the result arrives four edges after the sampling edge. A pipeline register missing or doubled moves every `out_valid` pulse by a cycle, and the latency check catches that on the first result.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
package trg_pkg;
  // Kind of work item travelling down the interpolation pipeline
  typedef enum logic [2:0] {
    K_FAST = 3'd0,
    K_S    = 3'd1,
    K_A    = 3'd2,
    K_B    = 3'd3,
    K_C    = 3'd4
  } kind_e;

  localparam logic [1:0] TAG_S = 2'd0;
  localparam logic [1:0] TAG_A = 2'd1;
  localparam logic [1:0] TAG_B = 2'd2;
  localparam logic [1:0] TAG_C = 2'd3;
endpackage

// File: rtl/trg_lerp.sv
`timescale 1ns/1ps
// One linear step: y = a + floor((b - a) * f / 2^FW)
module trg_lerp #(
  parameter int IW = 18,
  parameter int FW = 8
) (
  input  logic signed [IW-1:0] a,
  input  logic signed [IW-1:0] b,
  input  logic        [FW-1:0] f,
  output logic signed [IW-1:0] y
);
  localparam int PW = IW + FW + 2;

  logic signed [IW:0]   span;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] step;

  always_comb begin
    span = {b[IW-1], b} - {a[IW-1], a};
    prod = span * $signed({1'b0, f});
    step = prod >>> FW;
    y    = a + step[IW-1:0];
  end

  // R9: the result never leaves the interval spanned by the operands
  always_comb begin
    if (a <= b) begin
      assert_lerp_bounded_R9: assert (y >= a && y <= b)
        else $error("lerp result outside [a,b]");
    end else begin
      assert_lerp_bounded_rev_R9: assert (y >= b && y <= a)
        else $error("lerp result outside [b,a]");
    end
  end
endmodule

// File: rtl/trg_entry.sv
`timescale 1ns/1ps
// Input stage: tag sequencing, centre-set storage, per-corner half differences
module trg_entry
  import trg_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8,
  parameter int IW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic [1:0]           in_tag,
  input  logic [7:0][DW-1:0]   in_samples,
  input  logic [FW-1:0]        in_fx,
  input  logic [FW-1:0]        in_fy,
  input  logic [FW-1:0]        in_fz,
  output logic                 ev,
  output kind_e                ekind,
  output logic [7:0][IW-1:0]   ecorner,
  output logic [FW-1:0]        efx,
  output logic [FW-1:0]        efy,
  output logic [FW-1:0]        efz,
  output logic                 err
);
  logic [1:0]              exp_tag_q;
  logic [7:0][DW-1:0]      s_hold;
  logic [7:0][IW-1:0]      zext;
  logic [2:0][7:0][IW-1:0] dif;
  logic [7:0][IW-1:0]      sel;
  kind_e                   kind_n;
  logic                    tag_ok;
  logic                    take;

  // Per corner, per axis: central difference against the stored centre set
  for (genvar i = 0; i < 8; i++) begin : g_corner
    assign zext[i] = {{(IW-DW){1'b0}}, in_samples[i]};
    for (genvar ax = 0; ax < 3; ax++) begin : g_axis
      logic [DW:0] wide;
      logic [DW:0] half;
      if (((i >> ax) & 1) == 0) begin : g_near
        assign wide = {1'b0, s_hold[i ^ (1 << ax)]} - {1'b0, in_samples[i]};
      end else begin : g_far
        assign wide = {1'b0, in_samples[i]} - {1'b0, s_hold[i ^ (1 << ax)]};
      end
      assign half        = {wide[DW], wide[DW:1]};
      assign dif[ax][i]  = {{(IW-DW-1){half[DW]}}, half};
    end
  end

  always_comb begin
    tag_ok = (in_tag == exp_tag_q);
    take   = in_valid && (!in_mode || tag_ok);
    kind_n = K_FAST;
    sel    = zext;
    if (in_mode) begin
      unique case (in_tag)
        TAG_S: kind_n = K_S;
        TAG_A: begin kind_n = K_A; sel = dif[0]; end
        TAG_B: begin kind_n = K_B; sel = dif[1]; end
        default: begin kind_n = K_C; sel = dif[2]; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev        <= 1'b0;
      err       <= 1'b0;
      exp_tag_q <= TAG_S;
    end else begin
      ev  <= take;
      err <= in_valid && in_mode && !tag_ok;
      if (in_valid) begin
        if (!in_mode || !tag_ok) exp_tag_q <= TAG_S;
        else                     exp_tag_q <= in_tag + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      ecorner <= sel;
      ekind   <= kind_n;
      efx     <= in_fx;
      efy     <= in_fy;
      efz     <= in_fz;
    end
    if (take && in_mode && in_tag == TAG_S) s_hold <= in_samples;
  end

  // R7: the error flag only follows a quality-mode set
  assert_err_quality_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(in_valid && in_mode));
endmodule

// File: rtl/trg_interp.sv
`timescale 1ns/1ps
// Three-layer trilinear tree: 8 edge steps, 6 face steps, 1 final step
module trg_interp
  import trg_pkg::*;
#(
  parameter int IW = 18,
  parameter int FW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  kind_e                    in_kind,
  input  logic [7:0][IW-1:0]       corner,
  input  logic [FW-1:0]            fx,
  input  logic [FW-1:0]            fy,
  input  logic [FW-1:0]            fz,
  output logic                     v3,
  output kind_e                    kind3,
  output logic signed [IW-1:0]     d3,
  output logic signed [IW-1:0]     gx3,
  output logic signed [IW-1:0]     gy3,
  output logic signed [IW-1:0]     gz3
);
  localparam int NEDGE = 4;
  localparam int NFACE = 6;

  // ---- layer 1: edges ----
  logic signed [IW-1:0] ex_w [NEDGE];
  logic signed [IW-1:0] ey_w [NEDGE];
  logic signed [IW-1:0] ex_q [NEDGE];
  logic signed [IW-1:0] ey_q [NEDGE];
  logic [FW-1:0]        fy1, fz1;
  logic                 v1;
  kind_e                kind1;

  for (genvar k = 0; k < NEDGE; k++) begin : g_edge
    localparam int XA = 2 * k;                 // x-edge, k = {z,y}
    localparam int YA = (k / 2) * 4 + (k % 2); // y-edge, k = {z,x}
    trg_lerp #(.IW(IW), .FW(FW)) u_ex (
      .a(corner[XA]), .b(corner[XA+1]), .f(fx), .y(ex_w[k]));
    trg_lerp #(.IW(IW), .FW(FW)) u_ey (
      .a(corner[YA]), .b(corner[YA+2]), .f(fy), .y(ey_w[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    ex_q  <= ex_w;
    ey_q  <= ey_w;
    fy1   <= fy;
    fz1   <= fz;
    kind1 <= in_kind;
  end

  // ---- layer 2: faces (x0, x1, y0, y1, z0, z1) ----
  logic signed [IW-1:0] fa  [NFACE];
  logic signed [IW-1:0] fb  [NFACE];
  logic [FW-1:0]        ff  [NFACE];
  logic signed [IW-1:0] f_w [NFACE];
  logic signed [IW-1:0] f_q [NFACE];
  logic [FW-1:0]        fz2;
  logic                 v2;
  kind_e                kind2;

  always_comb begin
    fa[0] = ey_q[0]; fb[0] = ey_q[2]; ff[0] = fz1;
    fa[1] = ey_q[1]; fb[1] = ey_q[3]; ff[1] = fz1;
    fa[2] = ex_q[0]; fb[2] = ex_q[2]; ff[2] = fz1;
    fa[3] = ex_q[1]; fb[3] = ex_q[3]; ff[3] = fz1;
    fa[4] = ex_q[0]; fb[4] = ex_q[1]; ff[4] = fy1;
    fa[5] = ex_q[2]; fb[5] = ex_q[3]; ff[5] = fy1;
  end

  for (genvar n = 0; n < NFACE; n++) begin : g_face
    trg_lerp #(.IW(IW), .FW(FW)) u_face (
      .a(fa[n]), .b(fb[n]), .f(ff[n]), .y(f_w[n]));
  end

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    f_q   <= f_w;
    fz2   <= fz1;
    kind2 <= kind1;
  end

  // ---- layer 3: final step and face differences ----
  logic signed [IW-1:0] d_w;

  trg_lerp #(.IW(IW), .FW(FW)) u_final (
    .a(f_q[4]), .b(f_q[5]), .f(fz2), .y(d_w));

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    d3    <= d_w;
    gx3   <= f_q[1] - f_q[0];
    gy3   <= f_q[3] - f_q[2];
    gz3   <= f_q[5] - f_q[4];
    kind3 <= kind2;
  end
endmodule

// File: rtl/trilin_grad_extractor.sv
`timescale 1ns/1ps
module trilin_grad_extractor
  import trg_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  logic [1:0]           in_tag,
  input  logic [8*DW-1:0]      in_samples,
  input  logic [FW-1:0]        in_fx,
  input  logic [FW-1:0]        in_fy,
  input  logic [FW-1:0]        in_fz,
  output logic                 out_valid,
  output logic [DW-1:0]        out_value,
  output logic signed [DW:0]   out_gx,
  output logic signed [DW:0]   out_gy,
  output logic signed [DW:0]   out_gz,
  output logic                 out_err
);
  localparam int IW = DW + 2;
  localparam int GW = DW + 1;
  localparam logic signed [IW-1:0] VMAX = IW'((1 << DW) - 1);

  logic                 ev;
  kind_e                ekind;
  logic [7:0][IW-1:0]   ecorner;
  logic [FW-1:0]        efx, efy, efz;
  logic                 v3;
  kind_e                kind3;
  logic signed [IW-1:0] d3, gx3, gy3, gz3;
  logic [DW-1:0]        hold_v;
  logic [GW-1:0]        hold_x, hold_y;

  trg_entry #(.DW(DW), .FW(FW), .IW(IW)) u_entry (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_tag(in_tag), .in_samples(in_samples),
    .in_fx(in_fx), .in_fy(in_fy), .in_fz(in_fz),
    .ev(ev), .ekind(ekind), .ecorner(ecorner),
    .efx(efx), .efy(efy), .efz(efz), .err(out_err));

  trg_interp #(.IW(IW), .FW(FW)) u_interp (
    .clk(clk), .rst(rst), .in_valid(ev), .in_kind(ekind),
    .corner(ecorner), .fx(efx), .fy(efy), .fz(efz),
    .v3(v3), .kind3(kind3), .d3(d3), .gx3(gx3), .gy3(gy3), .gz3(gz3));

  // Result collector: fast results go straight out, quality passes gather
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_gx    <= '0;
      out_gy    <= '0;
      out_gz    <= '0;
      hold_v    <= '0;
      hold_x    <= '0;
      hold_y    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (v3) begin
        unique case (kind3)
          K_FAST: begin
            out_valid <= 1'b1;
            out_value <= d3[DW-1:0];
            out_gx    <= gx3[GW-1:0];
            out_gy    <= gy3[GW-1:0];
            out_gz    <= gz3[GW-1:0];
          end
          K_S: hold_v <= d3[DW-1:0];
          K_A: hold_x <= d3[GW-1:0];
          K_B: hold_y <= d3[GW-1:0];
          default: begin
            out_valid <= 1'b1;
            out_value <= hold_v;
            out_gx    <= hold_x;
            out_gy    <= hold_y;
            out_gz    <= d3[GW-1:0];
          end
        endcase
      end
    end
  end

  // R4 / R5: a result leaves exactly four edges after its set left the entry stage
  assert_out_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ev, 4));

  // R2: a reconstructed scalar stays inside the sample range
  assert_value_range_R2: assert property (@(posedge clk) disable iff (rst)
    (v3 && (kind3 == K_FAST || kind3 == K_S)) |-> (d3 >= 0 && d3 <= VMAX));

  // R3: fast-mode face differences fit the gradient port width
  assert_grad_width_R3: assert property (@(posedge clk) disable iff (rst)
    (v3 && kind3 == K_FAST) |->
      (gx3[IW-1] == gx3[GW-1] && gy3[IW-1] == gy3[GW-1] && gz3[IW-1] == gz3[GW-1]));
endmodule

// File: tb/test_trilin_grad_extractor.sv
`timescale 1ns/1ps
module test_trilin_grad_extractor;
  localparam int DW = 16;
  localparam int FW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_mode = 1'b0;
  logic [1:0]        in_tag = 2'd0;
  logic [8*DW-1:0]   in_samples = '0;
  logic [FW-1:0]     in_fx = '0, in_fy = '0, in_fz = '0;
  logic              out_valid;
  logic [DW-1:0]     out_value;
  logic signed [DW:0] out_gx, out_gy, out_gz;
  logic              out_err;

  trilin_grad_extractor #(.DW(DW), .FW(FW)) i_trilin_grad_extractor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_tag(in_tag), .in_samples(in_samples),
    .in_fx(in_fx), .in_fy(in_fy), .in_fz(in_fz),
    .out_valid(out_valid), .out_value(out_value),
    .out_gx(out_gx), .out_gy(out_gy), .out_gz(out_gz), .out_err(out_err));

  always #4 clk = ~clk;   // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int due;
    int v, gx, gy, gz;
    int lo, hi;
    bit qual;
  } exp_t;

  exp_t q[$];
  exp_t e;
  bit   exp_err[64];

  // reference model state for quality sequences
  int m_exp = 0;
  int m_s[8];
  int m_v, m_gx, m_gy;

  function automatic int lin(int a, int b, int f);
    return a + (((b - a) * f) >>> FW);
  endfunction

  task automatic model(input int c[8], input int fx, input int fy, input int fz,
                       output int d, output int gx, output int gy, output int gz);
    int xe[4];
    int ye[4];
    int x0, x1, y0, y1, z0, z1;
    for (int k = 0; k < 4; k++) begin
      xe[k] = lin(c[2*k], c[2*k+1], fx);                       // k = {z,y}
      ye[k] = lin(c[(k/2)*4 + (k%2)], c[(k/2)*4 + (k%2) + 2], fy); // k = {z,x}
    end
    x0 = lin(ye[0], ye[2], fz);
    x1 = lin(ye[1], ye[3], fz);
    y0 = lin(xe[0], xe[2], fz);
    y1 = lin(xe[1], xe[3], fz);
    z0 = lin(xe[0], xe[1], fy);
    z1 = lin(xe[2], xe[3], fy);
    d  = lin(z0, z1, fz);
    gx = x1 - x0;
    gy = y1 - y0;
    gz = z1 - z0;
  endtask

  task automatic check(input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // drive one set and update the expectation model
  task automatic send(input bit mode, input bit [1:0] tag, input int s[8],
                      input int fx, input int fy, input int fz);
    int d, gx, gy, gz;
    int nb[8];
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = mode;
    in_tag   = tag;
    for (int i = 0; i < 8; i++) in_samples[16*i +: 16] = s[i][15:0];
    in_fx = fx[7:0];
    in_fy = fy[7:0];
    in_fz = fz[7:0];
    if (!mode) begin
      model(s, fx, fy, fz, d, gx, gy, gz);
      x.due = cyc + 5; x.v = d; x.gx = gx; x.gy = gy; x.gz = gz; x.qual = 1'b0;
      x.lo = s[0]; x.hi = s[0];
      for (int i = 1; i < 8; i++) begin
        if (s[i] < x.lo) x.lo = s[i];
        if (s[i] > x.hi) x.hi = s[i];
      end
      q.push_back(x);
      m_exp = 0;                               // R8: sequence abandoned
    end else if (int'(tag) != m_exp) begin
      exp_err[(cyc + 1) % 64] = 1'b1;          // R7
      m_exp = 0;
    end else begin
      if (tag == 2'd0) begin
        m_s = s;
        model(s, fx, fy, fz, m_v, gx, gy, gz);
      end else begin
        for (int i = 0; i < 8; i++) begin
          int ax;
          int j;
          int w;
          ax = int'(tag) - 1;
          j  = i ^ (1 << ax);
          if (((i >> ax) & 1) == 0) w = m_s[j] - s[i];
          else                      w = s[i] - m_s[j];
          nb[i] = w >>> 1;                     // R6: floor halving
        end
        model(nb, fx, fy, fz, d, gx, gy, gz);
        if (tag == 2'd1) m_gx = d;
        if (tag == 2'd2) m_gy = d;
        if (tag == 2'd3) begin
          x.due = cyc + 5; x.v = m_v; x.gx = m_gx; x.gy = m_gy; x.gz = d;
          x.qual = 1'b1; x.lo = 0; x.hi = 0;
          q.push_back(x);
        end
      end
      m_exp = (int'(tag) + 1) % 4;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic rnd_set(output int s[8]);
    int pick;
    pick = int'($urandom % 8);
    for (int i = 0; i < 8; i++) begin
      if (pick == 0)      s[i] = (i % 2 == 0) ? 0 : 65535;
      else if (pick == 1) s[i] = ($urandom % 2 == 0) ? 0 : 65535;
      else                s[i] = int'($urandom % 65536);
    end
  endtask

  task automatic quality_seq(input int s0[8], input int gap);
    int fx, fy, fz;
    int nset[8];
    fx = int'($urandom % 256); fy = int'($urandom % 256); fz = int'($urandom % 256);
    send(1'b1, 2'd0, s0, fx, fy, fz);
    for (int t = 1; t < 4; t++) begin
      if (gap != 0 && ($urandom % 3 == 0)) idle(1);
      rnd_set(nset);
      send(1'b1, t[1:0], nset, fx, fy, fz);
    end
  endtask

  // output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_err || exp_err[cyc % 64])
        check("R7 error flag", int'(out_err), int'(exp_err[cyc % 64]));
      exp_err[cyc % 64] = 1'b0;
      if (out_valid) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R7 spurious result: actual=1 expected=0");
        end else begin
          e = q.pop_front();
          if (e.qual) begin
            check("R5 quality latency", cyc, e.due);
            check("R5 quality value", int'(out_value), e.v);
            check("R6 quality gx", int'(out_gx), e.gx);
            check("R6 quality gy", int'(out_gy), e.gy);
            check("R6 quality gz", int'(out_gz), e.gz);
          end else begin
            check("R4 fast latency", cyc, e.due);
            check("R2 fast value", int'(out_value), e.v);
            check("R3 fast gx", int'(out_gx), e.gx);
            check("R3 fast gy", int'(out_gy), e.gy);
            check("R3 fast gz", int'(out_gz), e.gz);
            total++;
            if (int'(out_value) < e.lo || int'(out_value) > e.hi) begin
              bad++;
              $display("FAIL R9 value outside corners: actual=%0d expected=[%0d,%0d]",
                       out_value, e.lo, e.hi);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s[8];
    int t[8];
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) exp_err[i] = 1'b0;

    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_err in reset", int'(out_err), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_value after reset", int'(out_value), 0);
    check("R1 out_gx after reset", int'(out_gx), 0);
    check("R1 out_err after reset", int'(out_err), 0);

    // R2/R3 directed: zero offset, full offset, ramp, extreme x step
    s = '{100, 200, 300, 400, 500, 600, 700, 800};
    send(1'b0, 2'd0, s, 0, 0, 0);
    send(1'b0, 2'd0, s, 255, 255, 255);
    send(1'b0, 2'd0, s, 128, 64, 192);
    s = '{0, 65535, 0, 65535, 0, 65535, 0, 65535};
    send(1'b0, 2'd0, s, 128, 0, 255);
    s = '{65535, 0, 65535, 0, 65535, 0, 65535, 0};
    send(1'b0, 2'd0, s, 1, 254, 7);
    idle(6);

    // R4: random fast sets back to back
    for (int n = 0; n < 300; n++) begin
      rnd_set(s);
      send(1'b0, 2'd0, s, int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
    end
    idle(6);

    // R5/R6 directed: extremes for the halving, then random sequences with gaps
    s = '{0, 65535, 0, 65535, 65535, 0, 65535, 0};
    t = '{65535, 0, 65535, 0, 0, 65535, 0, 65535};
    send(1'b1, 2'd0, s, 0, 0, 0);
    send(1'b1, 2'd1, t, 0, 0, 0);
    send(1'b1, 2'd2, t, 0, 0, 0);
    send(1'b1, 2'd3, t, 0, 0, 0);
    for (int n = 0; n < 60; n++) begin
      rnd_set(s);
      quality_seq(s, n % 2);
    end
    idle(6);

    // R7: out-of-order tags
    rnd_set(s);
    send(1'b1, 2'd1, s, 10, 20, 30);     // x set without centre
    send(1'b1, 2'd0, s, 10, 20, 30);
    send(1'b1, 2'd2, s, 10, 20, 30);     // skips x set
    send(1'b1, 2'd0, s, 10, 20, 30);
    send(1'b1, 2'd1, s, 10, 20, 30);
    send(1'b1, 2'd3, s, 10, 20, 30);     // skips y set
    send(1'b1, 2'd0, s, 10, 20, 30);
    send(1'b1, 2'd0, s, 10, 20, 30);     // repeated centre
    quality_seq(s, 0);
    idle(6);

    // R8: fast set in the middle of a quality sequence
    rnd_set(s);
    send(1'b1, 2'd0, s, 40, 50, 60);
    send(1'b1, 2'd1, s, 40, 50, 60);
    send(1'b0, 2'd2, s, 40, 50, 60);     // fast, no error
    send(1'b1, 2'd2, s, 40, 50, 60);     // now out of order
    quality_seq(s, 1);
    idle(6);

    // mixed random traffic: modes and tags at random
    for (int n = 0; n < 400; n++) begin
      rnd_set(s);
      if ($urandom % 4 == 0) idle(1);
      send(($urandom % 4) != 0, 2'(m_exp + (($urandom % 6 == 0) ? 1 : 0)), s,
           int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
    end
    idle(10);

    // R5: every expected result arrived
    check("R5 results outstanding", q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule